// File: doc/BRIEF.md
# Debug Host Command Sequencer

This block runs on the host side of a background-debug link. A requester hands it one command at a time: an 8-bit opcode, plus a 16-bit address and a 16-bit write word where the command needs them. The sequencer sorts the opcode into a command class. It then sends the fields that class uses, in a fixed order, over an abstract byte/word transmit port.

Between fields it holds a mandatory wait. That wait is counted in target debug-clock cycles, which arrive as an enable input. For read commands it then takes one 16-bit word from the receive port. Completion is reported through a busy level and a one-cycle done pulse that carries the read word.

Different command classes have different waits:

- Hardware reads wait a long gap between the address and the data.
- Writes wait the long gap after their data field.
- Firmware reads wait a short gap between the opcode and the data.
- Commands with no data send only their opcode.

Top module: `dbg_cmd_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy, done, tx_valid and rx_ready are all low.
- R2: A request is taken only in a cycle with req_valid high and busy low. A request presented while busy is high sends nothing and produces no done pulse.
- R3: Each field is sent as one transmit item held stable until tx_ready. The opcode always goes first, as a byte (tx_word=0, value in tx_data[7:0]). Address and data go as words (tx_word=1), with the address before the data.
- R4: Opcodes with upper nibble 0xE and bits [1:0]=00 (0xE0, 0xE4, 0xE8, 0xEC) are hardware reads. They send opcode and address, wait LONG_GAP debug-clock enables, then receive one full 16-bit word, even for byte-sized reads.
- R5: Opcodes with upper nibble 0xC and bits [1:0]=00 (0xC0, 0xC4, 0xC8, 0xCC) are hardware writes. They send opcode, address and data, then wait LONG_GAP enables before done.
- R6: Opcodes 0x62 to 0x67 are firmware reads. They send the opcode, wait SHORT_GAP enables, then receive one 16-bit word.
- R7: Opcodes 0x42 to 0x47 are firmware writes. They send the opcode and the data word, then wait LONG_GAP enables before done.
- R8: Opcodes 0x08, 0x10 and 0x18 send only the opcode. Done follows in the cycle after its handshake, with no wait.
- R9: Any other opcode is sent alone and followed by a LONG_GAP wait before done.
- R10: A wait advances only in cycles with dclk_en high. Its length in enables does not depend on the enable rate.
- R11: Done is high for exactly one cycle at the end of every command. rdata holds the last word received and changes only when a read completes.
- R12: A new request presented in the cycle done is high is accepted at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dclk_en | input | 1 | One-cycle pulse per target debug-clock cycle |
| req_valid | input | 1 | Command request present |
| req_opcode | input | 8 | Command opcode |
| req_addr | input | 16 | Address field |
| req_wdata | input | 16 | Write data field |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last word received |
| tx_valid | output | 1 | Transmit item present |
| tx_word | output | 1 | 1 = 16-bit item, 0 = 8-bit item |
| tx_data | output | 16 | Transmit item value |
| tx_ready | input | 1 | Link accepts the transmit item |
| rx_ready | output | 1 | Sequencer waits for the read word |
| rx_valid | input | 1 | Read word present |
| rx_data | input | 16 | Read word |

## Verification
The end of one command and the acceptance of the next can fall in the same cycle. This happens because done is raised in the cycle the sequencer returns to idle, which is also the first cycle busy is low.

The bench's driver waits only on busy, so every consecutive request lands on a done cycle. In those cycles the monitor requires busy to be high one cycle later. The scoreboard then requires the new opcode to appear in order with its own wait intact.

A stray request held during a long wait must leave the transmit stream and the done count untouched.

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq #(
  parameter int LONG_GAP  = 150,
  parameter int SHORT_GAP = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dclk_en,
  input  logic        req_valid,
  input  logic [7:0]  req_opcode,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        tx_valid,
  output logic        tx_word,
  output logic [15:0] tx_data,
  input  logic        tx_ready,
  output logic        rx_ready,
  input  logic        rx_valid,
  input  logic [15:0] rx_data
);
  localparam int GMAX = (LONG_GAP > SHORT_GAP) ? LONG_GAP : SHORT_GAP;
  localparam int CW   = $clog2(GMAX + 1);

  localparam logic [2:0] K_HWRD = 3'd0, K_HWWR = 3'd1, K_FWRD = 3'd2,
                         K_FWWR = 3'd3, K_NODAT = 3'd4, K_UNK = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADR, S_DAT, S_GAP, S_RX} st_t;

  st_t         st;
  logic [2:0]  cls;
  logic [7:0]  opc;
  logic [15:0] adr, wd;
  logic [CW-1:0] gap_len, cnt;
  logic        done_q;
  logic [15:0] rdata_q;

  function automatic logic [2:0] classify(input logic [7:0] op);
    if (op[7:4] == 4'hE && op[1:0] == 2'b00)      return K_HWRD;
    else if (op[7:4] == 4'hC && op[1:0] == 2'b00) return K_HWWR;
    else if (op >= 8'h62 && op <= 8'h67)          return K_FWRD;
    else if (op >= 8'h42 && op <= 8'h47)          return K_FWWR;
    else if (op == 8'h08 || op == 8'h10 || op == 8'h18) return K_NODAT;
    else                                          return K_UNK;
  endfunction

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign tx_valid = (st == S_OPC) || (st == S_ADR) || (st == S_DAT);
  assign tx_word  = (st != S_OPC);
  assign tx_data  = (st == S_OPC) ? {8'h00, opc} : (st == S_ADR) ? adr : wd;
  assign rx_ready = (st == S_RX);

  wire tx_fire  = tx_valid && tx_ready;
  wire is_read  = (cls == K_HWRD) || (cls == K_FWRD);
  wire gap_last = (cnt == gap_len - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cls     <= K_UNK;
      opc     <= 8'h00;
      adr     <= 16'h0;
      wd      <= 16'h0;
      gap_len <= '0;
      cnt     <= '0;
      done_q  <= 1'b0;
      rdata_q <= 16'h0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          opc <= req_opcode;
          adr <= req_addr;
          wd  <= req_wdata;
          cls <= classify(req_opcode);
          st  <= S_OPC;
        end
        S_OPC: if (tx_fire) begin
          case (cls)
            K_HWRD, K_HWWR: st <= S_ADR;
            K_FWWR:         st <= S_DAT;
            K_FWRD: begin
              gap_len <= CW'(SHORT_GAP);
              cnt     <= '0;
              st      <= S_GAP;
            end
            K_NODAT: begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
            default: begin
              gap_len <= CW'(LONG_GAP);
              cnt     <= '0;
              st      <= S_GAP;
            end
          endcase
        end
        S_ADR: if (tx_fire) begin
          if (cls == K_HWWR) st <= S_DAT;
          else begin
            gap_len <= CW'(LONG_GAP);
            cnt     <= '0;
            st      <= S_GAP;
          end
        end
        S_DAT: if (tx_fire) begin
          gap_len <= CW'(LONG_GAP);
          cnt     <= '0;
          st      <= S_GAP;
        end
        S_GAP: if (dclk_en) begin
          if (gap_last) begin
            cnt <= '0;
            if (is_read) st <= S_RX;
            else begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_RX: if (rx_valid) begin
          rdata_q <= rx_data;
          done_q  <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbg_cmd_seq_chk.sv
module dbg_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dclk_en,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdata,
  input logic        tx_valid,
  input logic        tx_word,
  input logic [15:0] tx_data,
  input logic        tx_ready,
  input logic        rx_ready,
  input logic        rx_valid,
  input logic [15:0] rx_data
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);

  assert_opcode_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_valid && !tx_word);

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_word));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> done && rdata == $past(rx_data));

  assert_gap_on_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(dclk_en));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk u_chk (.*);

// File: tb/dbg_cmd_seq_tb.sv
module dbg_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LONG  = 150;
  localparam int SHORT = 32;

  logic clk, rst_n, dclk_en, req_valid, busy, done, tx_valid, tx_word, tx_ready;
  logic rx_ready, rx_valid;
  logic [7:0]  req_opcode;
  logic [15:0] req_addr, req_wdata, rdata, tx_data, rx_data;

  dbg_cmd_seq #(.LONG_GAP(LONG), .SHORT_GAP(SHORT)) u_dut (
    .clk(clk), .rst_n(rst_n), .dclk_en(dclk_en), .req_valid(req_valid),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .tx_valid(tx_valid),
    .tx_word(tx_word), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data));

  int n_chk = 0, n_fail = 0, n_done = 0, n_issued = 0;
  logic [16:0] exp_tx[$];
  string       tx_tag[$];
  int          exp_gap[$];
  string       gap_tag[$];
  logic [16:0] exp_done[$];
  string       done_tag[$];
  logic [15:0] resp_q[$];
  logic [15:0] last_read = 16'h0;
  int en_period = 3;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    dclk_en = 0; tx_ready = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      dclk_en  = (cyc % en_period == 0);
      tx_ready = (cyc % 4 != 2);
    end
  end

  initial begin
    rx_valid = 0; rx_data = 0;
    forever begin
      @(posedge clk); #1;
      if (rx_ready && !rx_valid) begin
        rx_valid = 1;
        rx_data  = (resp_q.size() > 0) ? resp_q.pop_front() : 16'hDEAD;
      end else if (!rx_ready) rx_valid = 0;
    end
  end

  // scoreboard monitor
  bit armed = 0, prev_done = 0, pend_r12 = 0;
  int gcnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pend_r12) begin
          check(busy, "R12", "busy after request in done cycle", busy, 1);
          pend_r12 = 0;
        end
        if (done && req_valid) pend_r12 = 1;
        if (tx_valid && tx_ready) begin
          if (exp_tx.size() == 0)
            check(0, "R2", "unexpected transmit item", {tx_word, tx_data}, 0);
          else begin
            logic [16:0] e;
            string t;
            e = exp_tx.pop_front();
            t = tx_tag.pop_front();
            check({tx_word, tx_data} == e, t, "transmit item", {tx_word, tx_data}, e);
          end
          armed = 1; gcnt = 0;
        end else if (armed) begin
          if (rx_ready || done) begin
            if (exp_gap.size() == 0) check(0, "R2", "unexpected wait end", gcnt, 0);
            else begin
              int eg;
              string t;
              eg = exp_gap.pop_front();
              t  = gap_tag.pop_front();
              check(gcnt == eg, t, "wait length in enables", gcnt, eg);
            end
            armed = 0;
          end else if (dclk_en) gcnt++;
        end
        if (done) begin
          n_done++;
          check(!prev_done, "R11", "done longer than one cycle", 1, 0);
          if (exp_done.size() == 0) check(0, "R2", "unexpected done", 1, 0);
          else begin
            logic [16:0] d;
            string t;
            d = exp_done.pop_front();
            t = done_tag.pop_front();
            if (d[16]) begin
              check(rdata == d[15:0], t, "read word", rdata, d[15:0]);
              last_read = d[15:0];
            end else
              check(rdata == last_read, "R11", "rdata held over non-read", rdata, last_read);
          end
        end
        prev_done = done;
      end
    end
  end

  typedef enum {C_HWRD, C_HWWR, C_FWRD, C_FWWR, C_NODAT, C_UNK} kind_t;

  function automatic kind_t kind_of(input logic [7:0] op);
    if (op inside {8'hE0, 8'hE4, 8'hE8, 8'hEC}) return C_HWRD;
    if (op inside {8'hC0, 8'hC4, 8'hC8, 8'hCC}) return C_HWWR;
    if (op >= 8'h62 && op <= 8'h67) return C_FWRD;
    if (op >= 8'h42 && op <= 8'h47) return C_FWWR;
    if (op inside {8'h08, 8'h10, 8'h18}) return C_NODAT;
    return C_UNK;
  endfunction

  task automatic issue(input logic [7:0] op, input logic [15:0] a,
                       input logic [15:0] w, input logic [15:0] resp, input string tag);
    kind_t k;
    k = kind_of(op);
    exp_tx.push_back({1'b0, 8'h00, op}); tx_tag.push_back("R3");
    if (k == C_HWRD || k == C_HWWR) begin exp_tx.push_back({1'b1, a}); tx_tag.push_back(tag); end
    if (k == C_HWWR || k == C_FWWR) begin exp_tx.push_back({1'b1, w}); tx_tag.push_back(tag); end
    case (k)
      C_FWRD:  exp_gap.push_back(SHORT);
      C_NODAT: exp_gap.push_back(0);
      default: exp_gap.push_back(LONG);
    endcase
    gap_tag.push_back(tag);
    exp_done.push_back({(k == C_HWRD || k == C_FWRD), resp});
    done_tag.push_back(tag);
    if (k == C_HWRD || k == C_FWRD) resp_q.push_back(resp);
    while (busy) begin @(posedge clk); #1; end
    req_valid = 1; req_opcode = op; req_addr = a; req_wdata = w;
    n_issued++;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_opcode = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && !tx_valid && !rx_ready, "R1", "outputs in reset",
          {busy, done, tx_valid, rx_ready}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    check(!busy && !done && !tx_valid && !rx_ready, "R1", "outputs after reset",
          {busy, done, tx_valid, rx_ready}, 0);

    issue(8'hE8, 16'h1234, 16'h0000, 16'hBEEF, "R4");
    issue(8'hE0, 16'h0F00, 16'h0000, 16'h00AB, "R4");
    issue(8'hC8, 16'h2000, 16'h55AA, 16'h0, "R5");
    issue(8'hCC, 16'hFFFE, 16'h0001, 16'h0, "R5");
    issue(8'h63, 16'h0, 16'h0, 16'h1357, "R6");
    issue(8'h67, 16'h0, 16'h0, 16'h2468, "R6");
    issue(8'h43, 16'h0, 16'h8000, 16'h0, "R7");
    issue(8'h42, 16'h0, 16'h7FFF, 16'h0, "R7");
    issue(8'h08, 16'h0, 16'h0, 16'h0, "R8");
    issue(8'h10, 16'h0, 16'h0, 16'h0, "R8");
    issue(8'h18, 16'h0, 16'h0, 16'h0, "R8");
    issue(8'h7F, 16'h0, 16'h0, 16'h0, "R9");
    issue(8'h00, 16'h0, 16'h0, 16'h0, "R9");

    // R2: stray request during a long wait must be ignored
    issue(8'hE4, 16'h0400, 16'h0, 16'hC0DE, "R2");
    repeat (3) begin @(posedge clk); #1; end
    req_valid = 1; req_opcode = 8'h10;
    repeat (6) begin @(posedge clk); #1; end
    req_valid = 0;

    // R10: same waits at different enable rates
    while (busy) begin @(posedge clk); #1; end
    en_period = 1;
    issue(8'h64, 16'h0, 16'h0, 16'hA5A5, "R10");
    issue(8'hC4, 16'h3000, 16'h1111, 16'h0, "R10");
    while (busy) begin @(posedge clk); #1; end
    en_period = 5;
    issue(8'h65, 16'h0, 16'h0, 16'h5A5A, "R10");

    while (busy) begin @(posedge clk); #1; end
    repeat (4) begin @(posedge clk); #1; end
    check(exp_tx.size() == 0 && exp_gap.size() == 0 && exp_done.size() == 0, "R2",
          "scoreboard drained", exp_tx.size() + exp_done.size(), 0);
    check(n_done == n_issued, "R2", "done count", n_done, n_issued);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule